// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor

This block sits behind a T1 receive framer that is already aligned. Each valid byte arrives with its channel index (0 to 23) and its frame number within the multiframe, counted from 1. A format flag selects either the 12-frame superframe or the 24-frame extended superframe. In the signaling frames the block takes the least significant bit of every channel byte and writes it to one of four signaling positions, called A, B, C and D, for that channel. A 2-bit mode selects which frames go to which position, or turns extraction off.

The new bits are collected in a staging copy while the multiframe is in progress. At the multiframe boundary they are copied into a readable store in a single cycle. In that same cycle the block compares the staged set with the store it replaces. If any channel differs, a sticky change flag is set. The flag drives an interrupt line only when both a signaling-change enable and a framer-level enable are high. Software clears the flag by pulsing a clear strobe.

Top module: `rbs_extractor`

## Requirements
- R1: Mode code 01 is sixteen-code. In the 24-frame format, the LSBs of frames 6, 12, 18 and 24 go to positions A, B, C and D. On `rd_sig`, bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: Mode code 10 is four-code. In the 24-frame format, frames 6 and 18 write position A and frames 12 and 24 write position B. The later frame wins, and C and D keep their values.
- R3: Mode code 11 is two-code. Every signaling frame writes position A only, so A ends holding the last signaling frame's LSB (frame 24, or frame 12 in the 12-frame format). B, C and D keep their values.
- R4: In the 12-frame format (`esf_sel`=0), frame 6 feeds A and frame 12 feeds B under codes 01 and 10. C and D are left untouched.
- R5: Mode code 00 extracts nothing. The store does not change at the boundary and the change flag is not set.
- R6: Only bit 0 of bytes in signaling frames is used. Bits 7..1 of every byte, and all bytes of other frames, have no effect on the store.
- R7: Reads of the store during a multiframe return the values committed at the previous boundary. New values become visible on the clock edge after the edge that samples the last byte, which is channel 23 of the final frame.
- R8: `chg_sts` is set at a boundary where any committed channel value differs from the one it replaces. It stays set until `sts_clr` is pulsed. A set in the same cycle as a clear wins.
- R9: `sig_irq` is high exactly when `chg_sts`, `chg_ie` and `blk_ie` are all high.
- R10: A synchronous active-low reset clears both the store and the staging copy to zero and clears `chg_sts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received channel byte |
| rx_chan | input | 5 | Channel index, 0 to 23 |
| rx_frame | input | 5 | Frame number in the multiframe, from 1 |
| esf_sel | input | 1 | 1 selects 24-frame format, 0 selects 12-frame format |
| sig_mode | input | 2 | Extraction mode (00 off, 01 sixteen, 10 four, 11 two) |
| chg_ie | input | 1 | Signaling-change interrupt enable |
| blk_ie | input | 1 | Framer-level interrupt enable |
| sts_clr | input | 1 | Clear strobe for the change flag |
| rd_chan | input | 5 | Channel selected for readback |
| rd_sig | output | 4 | Committed signaling for `rd_chan` (bit 0 is A) |
| chg_sts | output | 1 | Sticky signaling-change flag |
| sig_irq | output | 1 | Gated signaling-change interrupt |

## Verification
The store and the change flag are registered twice after the input: once in the boundary detector and once at commit. Their new values are therefore due one clock edge after the edge that samples the final byte. The bench sends that byte and lowers `rx_valid`. It then reads the old value before the next edge (R7) and checks the new value and `chg_sts` after that edge. `rd_sig` and `sig_irq` are combinational from state, so the bench checks them after a short settling delay in the same cycle as it changes `rd_chan` or the enables.

// File: rtl/rbs_pkg.sv
// Package: shared types for the robbed-bit signaling extractor.
// Assumes a four-position signaling word (A..D) and a 2-bit mode code.
package rbs_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_SIXTEEN = 2'b01,
        MODE_FOUR    = 2'b10,
        MODE_TWO     = 2'b11
    } rbs_mode_e;

    localparam int SIG_POS = 4;           // A, B, C, D
    localparam int POS_W   = $clog2(SIG_POS);
    localparam int SIG_EVERY = 6;         // a signaling frame every sixth frame
endpackage

// File: rtl/rbs_slot_map.sv
// Module: rbs_slot_map
// Decides whether a frame carries signaling and which position (A..D)
// its LSB feeds under the selected mode. Purely combinational.
// Assumes frame numbers count from 1 and that the format flag is steady.
module rbs_slot_map
    import rbs_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic [FW-1:0]    frame,
    input  logic             esf,
    input  rbs_mode_e        mode,
    output logic             hit,
    output logic [POS_W-1:0] pos
);
    logic [1:0] k;        // index of the signaling frame within the multiframe
    logic       is_sig;

    // Find the signaling frame index from the frame number.
    always_comb begin
        is_sig = 1'b1;
        k      = 2'd0;
        if (frame == FW'(SIG_EVERY))        k = 2'd0;
        else if (frame == FW'(2*SIG_EVERY)) k = 2'd1;
        else if (frame == FW'(3*SIG_EVERY)) k = 2'd2;
        else if (frame == FW'(4*SIG_EVERY)) k = 2'd3;
        else                                is_sig = 1'b0;
    end

    // Map the frame index to a store position for the mode.
    always_comb begin
        hit = is_sig && (esf || !k[1]) && (mode != MODE_OFF);
        unique case (mode)
            MODE_SIXTEEN: pos = POS_W'(k);
            MODE_FOUR:    pos = POS_W'(k[0]);
            default:      pos = '0;
        endcase
    end
endmodule

// File: rtl/rbs_boundary.sv
// Module: rbs_boundary
// Flags the multiframe boundary with a one-cycle pulse in the cycle after
// the last channel of the last frame is accepted.
// Assumes the upstream framer delivers channels and frames in order.
module rbs_boundary #(
    parameter int NCH    = 24,
    parameter int FR_ESF = 24,
    parameter int FR_SF  = 12,
    parameter int CW     = 5,
    parameter int FW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [CW-1:0] chan,
    input  logic [FW-1:0] frame,
    input  logic          esf,
    output logic          mf_end
);
    logic [FW-1:0] last_frame;
    logic          last_byte;

    // Pick the final frame number for the current format.
    always_comb begin
        last_frame = esf ? FW'(FR_ESF) : FW'(FR_SF);
        last_byte  = valid && (chan == CW'(NCH-1)) && (frame == last_frame);
    end

    // Register the boundary pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) mf_end <= 1'b0;
        else        mf_end <= last_byte;
    end
endmodule

// File: rtl/rbs_sig_store.sv
// Module: rbs_sig_store
// Holds a staging copy and a committed copy of each channel's signaling word.
// A write updates a single staged bit, and a commit copies all staged words
// at once. The module also reports whether the staged set differs from the
// committed set.
// Assumes wr_pos is below SIGW.
module rbs_sig_store #(
    parameter int NCH  = 24,
    parameter int SIGW = 4,
    parameter int CW   = 5,
    parameter int PW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_chan,
    input  logic [PW-1:0]     wr_pos,
    input  logic              wr_bit,
    input  logic              commit,
    input  logic [CW-1:0]     rd_chan,
    output logic [SIGW-1:0]   rd_sig,
    output logic              differs,
    output logic [NCH*SIGW-1:0] store_flat
);
    logic [NCH*SIGW-1:0] stage_flat;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [SIGW-1:0] stg_q;
        logic [SIGW-1:0] sto_q;

        // Stage one signaling bit when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_q <= '0;
            else if (wr_en && (wr_chan == CW'(g)))
                stg_q[wr_pos] <= wr_bit;
        end

        // Commit the staged word at the boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)      sto_q <= '0;
            else if (commit) sto_q <= stg_q;
        end

        assign stage_flat[g*SIGW +: SIGW] = stg_q;
        assign store_flat[g*SIGW +: SIGW] = sto_q;
    end

    // Compare the staged set with the committed set across all channels.
    always_comb differs = |(stage_flat ^ store_flat);

    // Read back the committed word, with zero for an out-of-range index.
    always_comb begin
        if (int'(rd_chan) < NCH) rd_sig = store_flat[int'(rd_chan)*SIGW +: SIGW];
        else                     rd_sig = '0;
    end
endmodule

// File: rtl/rbs_extractor.sv
// Module: rbs_extractor (top)
// Extracts robbed-bit signaling from the T1 channel bytes into a per-channel
// A..D store. It commits the store at each multiframe boundary and raises a
// sticky change flag with a two-level gated interrupt.
// Assumes frame and channel alignment are already established upstream.
module rbs_extractor
    import rbs_pkg::*;
#(
    parameter int NCH    = 24,
    parameter int FR_ESF = 24,
    parameter int FR_SF  = 12,
    localparam int CW    = $clog2(NCH),
    localparam int FW    = $clog2(FR_ESF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [CW-1:0]     rx_chan,
    input  logic [FW-1:0]     rx_frame,
    input  logic              esf_sel,
    input  logic [1:0]        sig_mode,
    input  logic              chg_ie,
    input  logic              blk_ie,
    input  logic              sts_clr,
    input  logic [CW-1:0]     rd_chan,
    output logic [SIG_POS-1:0] rd_sig,
    output logic              chg_sts,
    output logic              sig_irq
);
    rbs_mode_e            mode;
    logic                 hit;
    logic [POS_W-1:0]     pos;
    logic                 mf_end;
    logic                 commit;
    logic                 differs;
    logic [NCH*SIG_POS-1:0] store_flat;
    logic                 unused_hi;

    assign mode      = rbs_mode_e'(sig_mode);
    assign unused_hi = ^rx_byte[7:1];

    rbs_slot_map #(.FW(FW)) u_map (
        .frame (rx_frame),
        .esf   (esf_sel),
        .mode  (mode),
        .hit   (hit),
        .pos   (pos)
    );

    rbs_boundary #(
        .NCH(NCH), .FR_ESF(FR_ESF), .FR_SF(FR_SF), .CW(CW), .FW(FW)
    ) u_bnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (rx_valid),
        .chan   (rx_chan),
        .frame  (rx_frame),
        .esf    (esf_sel),
        .mf_end (mf_end)
    );

    // Commit only while extraction is enabled.
    assign commit = mf_end && (mode != MODE_OFF);

    rbs_sig_store #(
        .NCH(NCH), .SIGW(SIG_POS), .CW(CW), .PW(POS_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (rx_valid && hit),
        .wr_chan    (rx_chan),
        .wr_pos     (pos),
        .wr_bit     (rx_byte[0]),
        .commit     (commit),
        .rd_chan    (rd_chan),
        .rd_sig     (rd_sig),
        .differs    (differs),
        .store_flat (store_flat)
    );

    // Sticky change flag: a set at commit has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 chg_sts <= 1'b0;
        else if (commit && differs) chg_sts <= 1'b1;
        else if (sts_clr)           chg_sts <= 1'b0;
    end

    // Interrupt line passes through both enable levels.
    always_comb sig_irq = chg_sts && chg_ie && blk_ie;
endmodule

// File: rtl/rbs_extractor_chk.sv
// Module: rbs_extractor_chk
// Checker bound to rbs_extractor. It watches the change flag, the interrupt
// gating and the stability of the committed store between boundaries.
module rbs_extractor_chk #(
    parameter int W = 96
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   sig_mode,
    input logic         chg_ie,
    input logic         blk_ie,
    input logic         sts_clr,
    input logic         chg_sts,
    input logic         sig_irq,
    input logic         mf_end,
    input logic         commit,
    input logic [W-1:0] store_flat
);
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sig_irq == (chg_sts && chg_ie && blk_ie));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        chg_sts && !sts_clr |=> chg_sts);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sts_clr && !commit |=> !chg_sts);

    a_r8_set_only_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_sts && !commit |=> !chg_sts);

    a_r7_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(store_flat));

    a_r5_off_inert: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end && (sig_mode == 2'b00) |=> $stable(store_flat) && !$rose(chg_sts));
endmodule

bind rbs_extractor rbs_extractor_chk #(.W(NCH*rbs_pkg::SIG_POS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_mode   (sig_mode),
    .chg_ie     (chg_ie),
    .blk_ie     (blk_ie),
    .sts_clr    (sts_clr),
    .chg_sts    (chg_sts),
    .sig_irq    (sig_irq),
    .mf_end     (mf_end),
    .commit     (commit),
    .store_flat (store_flat)
);

// File: tb/rbs_extractor_bench.sv
module rbs_extractor_bench;
    localparam int CLK_P = 10;
    localparam int NCH   = 24;

    // {esf, mode[1:0], lsb pattern[3:0], chg_ie, blk_ie}
    localparam logic [8:0] VEC [10] = '{
        {1'b1, 2'b01, 4'b1010, 2'b11},
        {1'b1, 2'b01, 4'b1010, 2'b11},
        {1'b1, 2'b10, 4'b0110, 2'b11},
        {1'b1, 2'b11, 4'b1001, 2'b11},
        {1'b0, 2'b01, 4'b0111, 2'b11},
        {1'b0, 2'b11, 4'b0001, 2'b11},
        {1'b1, 2'b00, 4'b1111, 2'b11},
        {1'b0, 2'b10, 4'b0010, 2'b01},
        {1'b1, 2'b01, 4'b0000, 2'b10},
        {1'b1, 2'b11, 4'b1110, 2'b11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [4:0] rx_chan = '0;
    logic [4:0] rx_frame = '0;
    logic       esf_sel = 1'b1;
    logic [1:0] sig_mode = '0;
    logic       chg_ie = 1'b0;
    logic       blk_ie = 1'b0;
    logic       sts_clr = 1'b0;
    logic [4:0] rd_chan = '0;
    logic [3:0] rd_sig;
    logic       chg_sts;
    logic       sig_irq;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] exp_e = '0;   // model for even channels
    logic [3:0] exp_o = '0;   // model for odd channels
    logic       exp_chg = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rbs_extractor u_rbs_extractor (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_chan(rx_chan), .rx_frame(rx_frame), .esf_sel(esf_sel),
        .sig_mode(sig_mode), .chg_ie(chg_ie), .blk_ie(blk_ie),
        .sts_clr(sts_clr), .rd_chan(rd_chan), .rd_sig(rd_sig),
        .chg_sts(chg_sts), .sig_irq(sig_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    // Model of the requirements: the new word from the prior word and the LSB pattern.
    function automatic logic [3:0] nxt(input logic [3:0] pv, input logic esf,
                                       input logic [1:0] m, input logic [3:0] p);
        logic [3:0] r = pv;
        if (m == 2'b01 && esf) r = p;                                        // R1
        else if ((m == 2'b01 || m == 2'b10) && !esf) r[1:0] = p[1:0];        // R4
        else if (m == 2'b10) begin r[0] = p[2]; r[1] = p[3]; end             // R2
        else if (m == 2'b11) r[0] = esf ? p[3] : p[1];                       // R3
        return r;
    endfunction

    function automatic string tag(input logic esf, input logic [1:0] m);
        if (m == 2'b00) return "R5";
        if (!esf)       return "R4/R6";
        if (m == 2'b01) return "R1/R6";
        if (m == 2'b10) return "R2/R6";
        return "R3/R6";
    endfunction

    // Feed frames 1..nfr. Odd channels carry the inverted pattern, and the
    // upper bits and non-signaling LSBs are scrambled.
    task automatic feed(input logic [3:0] p, input int nfr);
        for (int f = 1; f <= nfr; f++) begin
            for (int c = 0; c < NCH; c++) begin
                logic lsb;
                if (f % 6 == 0) lsb = p[f/6 - 1] ^ c[0];
                else            lsb = c[1] ^ f[0];
                rx_valid = 1'b1;
                rx_chan  = 5'(c);
                rx_frame = 5'(f);
                rx_byte  = {7'(c * 11 + f * 5), lsb};
                clk1();
            end
        end
        rx_valid = 1'b0;
    endtask

    task automatic read_ch(input int ch, output logic [3:0] v);
        rd_chan = 5'(ch);
        #1;
        v = rd_sig;
    endtask

    // Run one full multiframe and check stale read, new store, flag and irq.
    task automatic run_mf(input logic esf, input logic [1:0] m, input logic [3:0] p,
                          input logic cie, input logic bie, input logic clr_first);
        logic [3:0] v;
        logic [3:0] ne, no;
        esf_sel = esf; sig_mode = m; chg_ie = cie; blk_ie = bie;
        if (clr_first) begin
            sts_clr = 1'b1; clk1(); sts_clr = 1'b0; exp_chg = 1'b0;
        end
        feed(p, esf ? 24 : 12);
        read_ch(0, v);
        chk("R7 stale before commit", 8'(v), 8'(exp_e));
        ne = nxt(exp_e, esf, m, p);
        no = nxt(exp_o, esf, m, ~p);
        if (m != 2'b00 && (ne != exp_e || no != exp_o)) exp_chg = 1'b1;
        exp_e = ne; exp_o = no;
        clk1();
        read_ch(0, v);  chk(tag(esf, m), 8'(v), 8'(exp_e));
        read_ch(23, v); chk(tag(esf, m), 8'(v), 8'(exp_o));
        read_ch(10, v); chk(tag(esf, m), 8'(v), 8'(exp_e));
        chk("R8 change flag", 8'(chg_sts), 8'(exp_chg));
        chk("R9 irq gate", 8'(sig_irq), 8'(exp_chg & cie & bie));
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [3:0] v;
        clk1(); clk1();
        rst_n = 1'b1;
        clk1();
        read_ch(0, v);
        chk("R10 reset store", 8'(v), 8'h0);
        chk("R10 reset flag", 8'(chg_sts), 8'h0);

        // Table walk.
        foreach (VEC[i])
            run_mf(VEC[i][8], VEC[i][7:6], VEC[i][5:2], VEC[i][1], VEC[i][0], 1'b1);

        // R8: sticky without a clear, then cleared by the strobe.
        run_mf(1'b1, 2'b01, 4'b0101, 1'b1, 1'b1, 1'b1);
        run_mf(1'b1, 2'b01, 4'b0101, 1'b1, 1'b1, 1'b0);
        chk("R8 sticky", 8'(chg_sts), 8'h1);
        sts_clr = 1'b1; clk1(); sts_clr = 1'b0;
        chk("R8 cleared", 8'(chg_sts), 8'h0);

        // R9: each enable combination with the flag set.
        run_mf(1'b1, 2'b01, 4'b0011, 1'b1, 1'b1, 1'b1);
        for (int e = 0; e < 4; e++) begin
            chg_ie = e[1]; blk_ie = e[0];
            #1;
            chk("R9 enable combo", 8'(sig_irq), 8'(e == 3));
        end

        // R7: a partial multiframe leaves the store unchanged.
        esf_sel = 1'b1; sig_mode = 2'b01;
        feed(4'b1100, 20);
        clk1(); clk1();
        read_ch(0, v);
        chk("R7 mid multiframe", 8'(v), 8'(exp_e));

        // R10: reset in the middle of a stream clears everything.
        rst_n = 1'b0; clk1(); rst_n = 1'b1; clk1();
        read_ch(23, v);
        chk("R10 reset store", 8'(v), 8'h0);
        chk("R10 reset flag", 8'(chg_sts), 8'h0);
        exp_e = '0; exp_o = '0; exp_chg = 1'b0;

        // After the reset, a fresh multiframe with two-code in the 12-frame format.
        run_mf(1'b0, 2'b11, 4'b0010, 1'b1, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule